// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps a small group of private, direct-mapped caches coherent over one shared snooping bus. Each core owns a request port on which it issues a read, a write, an atomic fetch-and-add, or an eviction for a line address. Every cache line holds a tag, one data word and a four-state coherence tag. The tag is Modified, Exclusive, Shared or Invalid.

A round-robin arbiter picks one pending core at a time. The controller first looks the line up in that core's array. It completes hits locally where the protocol allows it. Otherwise it broadcasts a bus transaction that every other cache snoops. Snoopers that hold the line change state. A dirty owner supplies its data and writes it to memory. A wired-OR shared signal decides whether a reader fills clean-exclusive or shared. Dirty victims and evicted dirty lines go to memory through a simple write port. Completion is returned to the requester together with the returned data word and the line's final state.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset no line is valid. A read to a line that no other cache holds issues one bus Read (bus_op 01) with bus_shared low, returns the memory word, and leaves the line Exclusive (state code 10; codes are I=00, S=01, E=10, M=11).
- R2: A read miss while another cache holds the line valid issues a bus Read with bus_shared high and fills Shared (01). An Exclusive snooper drops to Shared.
- R3: A read hit in Modified, Exclusive or Shared completes with no bus transaction, returns the cached word and keeps the state.
- R4: When a bus Read finds the line Modified in another cache, that owner writes its word to memory in the same bus cycle and drops to Shared. The requester receives the owner's word.
- R5: A write to a line held Shared or Invalid issues one bus Read-Exclusive (bus_op 10). All other copies become Invalid, and the requester ends Modified holding the written word.
- R6: A write to a line held Exclusive or Modified completes with no bus transaction and leaves the line Modified.
- R7: An atomic fetch-and-add (command 10) always issues a bus Read-Exclusive, even when the requester already holds the line alone. It returns the old word, stores old plus the operand, and leaves the line Modified.
- R8: Evicting a Modified line (command 11) issues a bus Writeback (bus_op 11) carrying the word to memory and leaves the line Invalid. Evicting a clean line, or an address not present, issues no bus transaction, invalidates only a matching line, and leaves other lines untouched.
- R9: A miss whose direct-mapped slot holds a different, Modified line first writes that victim back to memory as a bus Writeback, then issues the miss transaction. A clean victim is dropped silently.
- R10: Only one request is served at a time. Simultaneous requests are granted in rotating order, starting after the core served last.
- R11: A Read-Exclusive that finds a Modified owner writes the owner's word to memory before the requester completes. The requester operates on the owner's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CORES | Per-core request pending; held until the matching done pulse |
| req_cmd | input | 2*N_CORES | Per-core command: 00 read, 01 write, 10 fetch-and-add, 11 evict |
| req_addr | input | ADDR_W*N_CORES | Per-core line address |
| req_wdata | input | DATA_W*N_CORES | Per-core write word or addend |
| resp_done | output | N_CORES | One-cycle completion pulse per core |
| resp_rdata | output | DATA_W*N_CORES | Returned word, valid with the done pulse |
| resp_state | output | 2*N_CORES | Final line state, valid with the done pulse |
| bus_valid | output | 1 | A bus transaction is broadcast this cycle |
| bus_op | output | 2 | Bus transaction: 01 Read, 10 Read-Exclusive, 11 Writeback |
| bus_addr | output | ADDR_W | Line address on the bus |
| bus_shared | output | 1 | Wired-OR of other caches holding the line valid |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address (read combinationally, written on the clock) |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word for mem_addr |

## Verification
Two functions meet in a single bus cycle: a dirty owner's writeback to memory and the requester's fill from that same owner. The bench provokes this in two ways. A core first dirties a line, then another core reads it. A core also runs fetch-and-add on a line that a third core modified. In the cycle after each request completes, the bench checks that memory holds the owner's word, that the requester's returned word and state match, and that the former owner's later hit reports the downgraded state. The bench also raises four requests in the same cycle and judges the rotating grant order from the order of completions and bus addresses.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR  = 2'b01,
    CMD_RMW = 2'b10,
    CMD_EV  = 2'b11
  } cmd_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'b00,
    BUS_RD   = 2'b01,
    BUS_RDX  = 2'b10,
    BUS_WB   = 2'b11
  } busop_t;

  // State a snooping cache takes when a bus transaction hits its line.
  function automatic mesi_t snoop_next(mesi_t cur, busop_t op);
    mesi_t nxt;
    nxt = cur;
    case (op)
      BUS_RD:  if (cur == ST_M || cur == ST_E) nxt = ST_S;
      BUS_RDX: nxt = ST_I;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  // Fill state of a read miss given the wired-OR shared signal.
  function automatic mesi_t read_fill(logic shared);
    return shared ? ST_S : ST_E;
  endfunction

  // Sole ownership allows a local write.
  function automatic logic owns_line(mesi_t s);
    return (s == ST_E) || (s == ST_M);
  endfunction

endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             take,
  output logic [N_REQ-1:0] gnt,
  output logic [IDX_W-1:0] gnt_idx
);

  logic [IDX_W-1:0] last_q;
  logic             found;

  // Search starts one past the last winner and wraps around.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 1; k <= N_REQ; k++) begin
      int cand;
      cand = (int'(last_q) + k) % N_REQ;
      if (!found && req[IDX_W'(cand)]) begin
        found                = 1'b1;
        gnt[IDX_W'(cand)]    = 1'b1;
        gnt_idx              = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_q <= IDX_W'(N_REQ - 1);
    else if (take && found)
      last_q <= gnt_idx;
  end

  a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r10_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0));

endmodule

// File: rtl/mesi_l1_array.sv
module mesi_l1_array
  import mesi_pkg::*;
#(
  parameter int SET_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int SETS  = 1 << SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic [TAG_W-1:0]  line_tag,
  output mesi_t             line_state,
  output logic [DATA_W-1:0] line_data,
  output logic              tag_hit,
  input  logic              snp_en,
  input  busop_t            snp_op,
  input  logic              wr_en,
  input  mesi_t             wr_state,
  input  logic [DATA_W-1:0] wr_data
);

  logic [TAG_W-1:0]  tag_q  [SETS];
  mesi_t             st_q   [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  assign line_tag   = tag_q[idx];
  assign line_state = st_q[idx];
  assign line_data  = data_q[idx];
  assign tag_hit    = (st_q[idx] != ST_I) && (tag_q[idx] == cmp_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        st_q[s]   <= ST_I;
        data_q[s] <= '0;
      end
    end else if (wr_en) begin
      tag_q[idx]  <= cmp_tag;
      st_q[idx]   <= wr_state;
      data_q[idx] <= wr_data;
    end else if (snp_en && tag_hit) begin
      st_q[idx] <= snoop_next(st_q[idx], snp_op);
    end
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int SET_W   = 2,
  parameter int DATA_W  = 16,
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int CID_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES-1:0]        req_valid,
  input  logic [2*N_CORES-1:0]      req_cmd,
  input  logic [ADDR_W*N_CORES-1:0] req_addr,
  input  logic [DATA_W*N_CORES-1:0] req_wdata,
  output logic [N_CORES-1:0]        resp_done,
  output logic [DATA_W*N_CORES-1:0] resp_rdata,
  output logic [2*N_CORES-1:0]      resp_state,
  output logic                      bus_valid,
  output logic [1:0]                bus_op,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic                      bus_shared,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata
);

  typedef enum logic [2:0] {
    F_IDLE, F_LOOK, F_VWB, F_BUS, F_EWB, F_DONE
  } fsm_t;

  // Word left in the line once the command is applied.
  function automatic logic [DATA_W-1:0] line_after(cmd_t c, logic [DATA_W-1:0] old,
                                                   logic [DATA_W-1:0] w);
    case (c)
      CMD_WR:  return w;
      CMD_RMW: return old + w;
      default: return old;
    endcase
  endfunction

  // Word handed back to the core.
  function automatic logic [DATA_W-1:0] reply_word(cmd_t c, logic [DATA_W-1:0] old,
                                                   logic [DATA_W-1:0] w);
    return (c == CMD_WR) ? w : old;
  endfunction

  fsm_t              fsm_q;
  logic [CID_W-1:0]  cur_core;
  cmd_t              cur_cmd;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] base_data;
  mesi_t             fin_state;

  logic [N_CORES-1:0] gnt;
  logic [CID_W-1:0]   gnt_idx;
  logic               arb_take;

  logic [1:0]        in_cmd   [N_CORES];
  logic [ADDR_W-1:0] in_addr  [N_CORES];
  logic [DATA_W-1:0] in_wdata [N_CORES];

  logic [TAG_W-1:0]  ln_tag   [N_CORES];
  mesi_t             ln_state [N_CORES];
  logic [DATA_W-1:0] ln_data  [N_CORES];
  logic [N_CORES-1:0] ln_hit;
  logic [N_CORES-1:0] snp_en;
  logic [N_CORES-1:0] wr_en;
  logic [N_CORES-1:0] owner_m;
  logic [N_CORES-1:0] self_mask;
  logic [N_CORES-1:0] other_hit;

  logic [TAG_W-1:0]  cur_tag;
  logic [SET_W-1:0]  cur_idx;
  logic              rq_hit;
  mesi_t             rq_state;
  logic [TAG_W-1:0]  rq_tag;
  logic [DATA_W-1:0] rq_data;
  logic              victim_dirty;
  logic              shared_any;
  logic [DATA_W-1:0] owner_data;
  logic [DATA_W-1:0] new_data;
  logic [DATA_W-1:0] reply_data;
  busop_t            bus_op_now;

  assign cur_tag = cur_addr[ADDR_W-1:SET_W];
  assign cur_idx = cur_addr[SET_W-1:0];

  // Arbitration
  assign arb_take = (fsm_q == F_IDLE) && (|req_valid);

  mesi_rr_arb #(.N_REQ(N_CORES)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .take    (arb_take),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  // Per-core slices, caches and snoop hookup
  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    assign in_cmd[g]   = req_cmd[2*g +: 2];
    assign in_addr[g]  = req_addr[ADDR_W*g +: ADDR_W];
    assign in_wdata[g] = req_wdata[DATA_W*g +: DATA_W];

    assign snp_en[g]  = (fsm_q == F_BUS) && (cur_core != CID_W'(g));
    assign wr_en[g]   = (fsm_q == F_DONE) && (cur_core == CID_W'(g)) &&
                        ((cur_cmd != CMD_EV) || ln_hit[g]);
    assign owner_m[g] = other_hit[g] && (ln_state[g] == ST_M);

    mesi_l1_array #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (cur_idx),
      .cmp_tag    (cur_tag),
      .line_tag   (ln_tag[g]),
      .line_state (ln_state[g]),
      .line_data  (ln_data[g]),
      .tag_hit    (ln_hit[g]),
      .snp_en     (snp_en[g]),
      .snp_op     (bus_op_now),
      .wr_en      (wr_en[g]),
      .wr_state   (fin_state),
      .wr_data    (new_data)
    );

    assign resp_done[g]                   = (fsm_q == F_DONE) && (cur_core == CID_W'(g));
    assign resp_rdata[DATA_W*g +: DATA_W] = resp_done[g] ? reply_data : '0;
    assign resp_state[2*g +: 2]           = resp_done[g] ? fin_state : ST_I;
  end

  // Requester view and snoop gathering
  assign rq_hit       = ln_hit[cur_core];
  assign rq_state     = ln_state[cur_core];
  assign rq_tag       = ln_tag[cur_core];
  assign rq_data      = ln_data[cur_core];
  assign victim_dirty = (rq_state == ST_M) && (rq_tag != cur_tag);

  assign self_mask  = {{(N_CORES-1){1'b0}}, 1'b1} << cur_core;
  assign other_hit  = ln_hit & ~self_mask;
  assign shared_any = |other_hit;

  always_comb begin
    owner_data = '0;
    for (int unsigned i = 0; i < N_CORES; i++)
      if (owner_m[CID_W'(i)]) owner_data = owner_data | ln_data[CID_W'(i)];
  end

  assign new_data   = line_after(cur_cmd, base_data, cur_wdata);
  assign reply_data = reply_word(cur_cmd, base_data, cur_wdata);

  // Bus and memory drive
  always_comb begin
    case (fsm_q)
      F_VWB, F_EWB: bus_op_now = BUS_WB;
      F_BUS:        bus_op_now = (cur_cmd == CMD_RD) ? BUS_RD : BUS_RDX;
      default:      bus_op_now = BUS_NONE;
    endcase
  end

  assign bus_valid  = (bus_op_now != BUS_NONE);
  assign bus_op     = bus_op_now;
  assign bus_addr   = (fsm_q == F_VWB) ? {rq_tag, cur_idx} : cur_addr;
  assign bus_shared = (fsm_q == F_BUS) && shared_any;
  assign mem_addr   = bus_addr;
  assign mem_we     = (fsm_q == F_VWB) || (fsm_q == F_EWB) ||
                      ((fsm_q == F_BUS) && (|owner_m));
  assign mem_wdata  = (fsm_q == F_BUS) ? owner_data : rq_data;

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      cur_core  <= '0;
      cur_cmd   <= CMD_RD;
      cur_addr  <= '0;
      cur_wdata <= '0;
      base_data <= '0;
      fin_state <= ST_I;
    end else begin
      case (fsm_q)
        F_IDLE: if (arb_take) begin
          cur_core  <= gnt_idx;
          cur_cmd   <= cmd_t'(in_cmd[gnt_idx]);
          cur_addr  <= in_addr[gnt_idx];
          cur_wdata <= in_wdata[gnt_idx];
          fsm_q     <= F_LOOK;
        end
        F_LOOK: begin
          base_data <= rq_hit ? rq_data : '0;
          case (cur_cmd)
            CMD_RD:
              if (rq_hit) begin
                fin_state <= rq_state;
                fsm_q     <= F_DONE;
              end else fsm_q <= victim_dirty ? F_VWB : F_BUS;
            CMD_WR:
              if (rq_hit && owns_line(rq_state)) begin
                fin_state <= ST_M;
                fsm_q     <= F_DONE;
              end else fsm_q <= victim_dirty ? F_VWB : F_BUS;
            CMD_RMW:
              fsm_q <= victim_dirty ? F_VWB : F_BUS;
            default: begin
              fin_state <= ST_I;
              fsm_q     <= (rq_hit && rq_state == ST_M) ? F_EWB : F_DONE;
            end
          endcase
        end
        F_VWB: fsm_q <= F_BUS;
        F_BUS: begin
          base_data <= (|owner_m) ? owner_data : (rq_hit ? rq_data : mem_rdata);
          fin_state <= (cur_cmd == CMD_RD) ? read_fill(shared_any) : ST_M;
          fsm_q     <= F_DONE;
        end
        F_EWB:  fsm_q <= F_DONE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  // Protocol checks
  a_r10_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_done));
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(owner_m) <= 1));
  a_r5_rdx_clears_others: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_BUS && bus_op_now == BUS_RDX) |=> (other_hit == '0));
  a_r2_exclusive_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_DONE && fin_state == ST_E) |-> (other_hit == '0));
  a_r8_mem_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bus_valid);
  a_r6_local_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_LOOK && cur_cmd == CMD_WR && rq_hit && owns_line(rq_state))
      |=> !bus_valid);

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, RMW = 2'b10, EV = 2'b11;
  localparam logic [1:0] BRD = 2'b01, BRDX = 2'b10, BWB = 2'b11;
  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [2*NC-1:0]   req_cmd = '0;
  logic [AW*NC-1:0]  req_addr = '0;
  logic [DW*NC-1:0]  req_wdata = '0;
  logic [NC-1:0]     resp_done;
  logic [DW*NC-1:0]  resp_rdata;
  logic [2*NC-1:0]   resp_state;
  logic              bus_valid;
  logic [1:0]        bus_op;
  logic [AW-1:0]     bus_addr;
  logic              bus_shared;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  mesi_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
    .resp_rdata(resp_rdata), .resp_state(resp_state), .bus_valid(bus_valid),
    .bus_op(bus_op), .bus_addr(bus_addr), .bus_shared(bus_shared),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Memory model: initial word of address a is 0x1000 + a
  logic [DW-1:0] mem_model [256];
  initial for (int i = 0; i < 256; i++) mem_model[i] = 16'h1000 + 16'(i);
  always @(posedge clk) if (mem_we) mem_model[mem_addr] <= mem_wdata;
  assign mem_rdata = mem_model[mem_addr];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard of expected completions
  int            sb_core [$];
  logic [DW-1:0] sb_data [$];
  logic [1:0]    sb_st   [$];
  string         sb_tag  [$];

  // Bus log
  logic [1:0]    bl_op   [$];
  logic [AW-1:0] bl_addr [$];
  bit            bl_sh   [$];

  task automatic push_exp(int c, logic [DW-1:0] d, logic [1:0] s, string tag);
    sb_core.push_back(c); sb_data.push_back(d); sb_st.push_back(s); sb_tag.push_back(tag);
  endtask

  // Monitor: compare completions and record bus traffic between clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid) begin
        bl_op.push_back(bus_op); bl_addr.push_back(bus_addr); bl_sh.push_back(bus_shared);
      end
      for (int c = 0; c < NC; c++) begin
        if (resp_done[c]) begin
          if (sb_core.size() == 0) begin
            chk(0, "R10", "unexpected completion core", c, 0);
          end else begin
            int ec; logic [DW-1:0] ed; logic [1:0] es; string et;
            ec = sb_core.pop_front(); ed = sb_data.pop_front();
            es = sb_st.pop_front(); et = sb_tag.pop_front();
            chk(c == ec, et, "completing core", c, ec);
            chk(resp_rdata[c*DW +: DW] == ed, et, "returned word", resp_rdata[c*DW +: DW], ed);
            chk(resp_state[c*2 +: 2] == es, et, "final state", resp_state[c*2 +: 2], es);
          end
        end
      end
    end
  end

  task automatic raw_req(int c, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] w);
    req_cmd[c*2 +: 2]     = cmd;
    req_addr[c*AW +: AW]  = a;
    req_wdata[c*DW +: DW] = w;
    req_valid[c]          = 1'b1;
    @(negedge clk);
    while (!resp_done[c]) @(negedge clk);
    req_valid[c] = 1'b0;
  endtask

  // Driver: one request with its expected completion and bus traffic
  task automatic do_op(int c, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] w,
                       logic [DW-1:0] ed, logic [1:0] es, int nbus,
                       logic [1:0] op0, logic [AW-1:0] a0,
                       logic [1:0] op1, logic [AW-1:0] a1, string tag);
    bl_op.delete(); bl_addr.delete(); bl_sh.delete();
    push_exp(c, ed, es, tag);
    raw_req(c, cmd, a, w);
    chk(bl_op.size() == nbus, tag, "bus transaction count", bl_op.size(), nbus);
    if (nbus >= 1 && bl_op.size() >= 1) begin
      chk(bl_op[0] == op0, tag, "first bus op", bl_op[0], op0);
      chk(bl_addr[0] == a0, tag, "first bus addr", bl_addr[0], a0);
    end
    if (nbus >= 2 && bl_op.size() >= 2) begin
      chk(bl_op[1] == op1, tag, "second bus op", bl_op[1], op1);
      chk(bl_addr[1] == a1, tag, "second bus addr", bl_addr[1], a1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(resp_done == '0, "R1", "done after reset", resp_done, 0);
    chk(!bus_valid, "R1", "bus after reset", bus_valid, 0);
    chk(!mem_we, "R1", "mem write after reset", mem_we, 0);

    do_op(0, RD, 8'h10, 0, 16'h1010, SE, 1, BRD, 8'h10, 0, 0, "R1");
    chk(bl_sh.size() > 0 && !bl_sh[0], "R1", "shared on lone read", bl_sh.size() > 0 ? bl_sh[0] : 1'b1, 0);
    do_op(1, RD, 8'h10, 0, 16'h1010, SS, 1, BRD, 8'h10, 0, 0, "R2");
    chk(bl_sh.size() > 0 && bl_sh[0], "R2", "shared on second read", bl_sh.size() > 0 ? bl_sh[0] : 1'b0, 1);
    do_op(0, RD, 8'h10, 0, 16'h1010, SS, 0, 0, 0, 0, 0, "R2_R3");
    do_op(0, WR, 8'h10, 16'hAAAA, 16'hAAAA, SM, 1, BRDX, 8'h10, 0, 0, "R5");
    do_op(1, RD, 8'h10, 0, 16'hAAAA, SS, 1, BRD, 8'h10, 0, 0, "R4_R5");
    chk(mem_model[8'h10] == 16'hAAAA, "R4", "owner writeback", mem_model[8'h10], 16'hAAAA);
    do_op(0, RD, 8'h10, 0, 16'hAAAA, SS, 0, 0, 0, 0, 0, "R4");

    do_op(2, RD, 8'h20, 0, 16'h1020, SE, 1, BRD, 8'h20, 0, 0, "R1");
    do_op(2, WR, 8'h20, 16'h5555, 16'h5555, SM, 0, 0, 0, 0, 0, "R6");
    do_op(2, WR, 8'h20, 16'h6666, 16'h6666, SM, 0, 0, 0, 0, 0, "R6");
    do_op(3, RMW, 8'h20, 16'h0001, 16'h6666, SM, 1, BRDX, 8'h20, 0, 0, "R7_R11");
    chk(mem_model[8'h20] == 16'h6666, "R11", "owner writeback on exclusive", mem_model[8'h20], 16'h6666);
    do_op(3, RMW, 8'h20, 16'h0002, 16'h6667, SM, 1, BRDX, 8'h20, 0, 0, "R7");
    do_op(3, RD, 8'h20, 0, 16'h6669, SM, 0, 0, 0, 0, 0, "R3");
    do_op(2, RD, 8'h20, 0, 16'h6669, SS, 1, BRD, 8'h20, 0, 0, "R4");
    chk(mem_model[8'h20] == 16'h6669, "R4", "writeback after atomics", mem_model[8'h20], 16'h6669);

    do_op(1, RD, 8'h30, 0, 16'h1030, SE, 1, BRD, 8'h30, 0, 0, "R9");
    do_op(1, WR, 8'h30, 16'h1234, 16'h1234, SM, 0, 0, 0, 0, 0, "R6");
    do_op(1, RD, 8'h14, 0, 16'h1014, SE, 2, BWB, 8'h30, BRD, 8'h14, "R9");
    chk(mem_model[8'h30] == 16'h1234, "R9", "victim in memory", mem_model[8'h30], 16'h1234);

    do_op(0, EV, 8'h10, 0, 16'hAAAA, SI, 0, 0, 0, 0, 0, "R8");
    do_op(0, RD, 8'h10, 0, 16'hAAAA, SE, 1, BRD, 8'h10, 0, 0, "R8");
    do_op(0, WR, 8'h10, 16'hBEEF, 16'hBEEF, SM, 0, 0, 0, 0, 0, "R6");
    do_op(0, EV, 8'h10, 0, 16'hBEEF, SI, 1, BWB, 8'h10, 0, 0, "R8");
    chk(mem_model[8'h10] == 16'hBEEF, "R8", "evict writeback", mem_model[8'h10], 16'hBEEF);
    do_op(3, RD, 8'h10, 0, 16'hBEEF, SE, 1, BRD, 8'h10, 0, 0, "R8");
    do_op(2, EV, 8'h3C, 0, 16'h0000, SI, 0, 0, 0, 0, 0, "R8");
    do_op(2, RD, 8'h20, 0, 16'h6669, SS, 0, 0, 0, 0, 0, "R8");

    // R10: four simultaneous requests; core 2 was served last
    bl_op.delete(); bl_addr.delete(); bl_sh.delete();
    push_exp(3, 16'h1043, SE, "R10");
    push_exp(0, 16'h1040, SE, "R10");
    push_exp(1, 16'h1041, SE, "R10");
    push_exp(2, 16'h1042, SE, "R10");
    fork
      raw_req(0, RD, 8'h40, 0);
      raw_req(1, RD, 8'h41, 0);
      raw_req(2, RD, 8'h42, 0);
      raw_req(3, RD, 8'h43, 0);
    join
    chk(bl_op.size() == 4, "R10", "bus count", bl_op.size(), 4);
    if (bl_addr.size() == 4) begin
      chk(bl_addr[0] == 8'h43, "R10", "grant order 1", bl_addr[0], 8'h43);
      chk(bl_addr[1] == 8'h40, "R10", "grant order 2", bl_addr[1], 8'h40);
      chk(bl_addr[2] == 8'h41, "R10", "grant order 3", bl_addr[2], 8'h41);
      chk(bl_addr[3] == 8'h42, "R10", "grant order 4", bl_addr[3], 8'h42);
    end
    repeat (2) @(negedge clk);
    chk(sb_core.size() == 0, "R10", "outstanding completions", sb_core.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule